// File: doc/BRIEF.md
# Descriptor-Chained DMA Transfer Engine

This block is one DMA channel. When started, it reads a four-word descriptor from memory. The four words are the next-descriptor pointer, the source address, the target address and a command word. It then copies data from source to target in bursts. Each burst reads every element of the burst into a local byte buffer and then writes every element out. The command word sets the element width, the burst size, whether each address steps or stays fixed, and whether a peripheral request gates the transfer. The remaining byte count is written back into the command register as the transfer proceeds.

Chaining is driven by the surrounding system. At completion the channel holds the next-descriptor pointer, so a further start fetches the next descriptor from it. A pointer flag combined with an external compare-status input selects an alternate descriptor 32 bytes further on. A flow-controlled transfer can end early when its request drops, and it can then jump straight to the next descriptor. In a register-only mode the channel skips the fetch and runs from its programmed registers. Memory is reached through a valid/ready port with one access in flight. Data is little-endian and right-aligned on the data bus.

Top module: `dce_engine`

## Requirements
- R1: After reset the channel is stopped (`st_stop`=1), `run`=0, the other status flags are 0, the channel registers are 0 and no memory request is made.
- R2: On `go` with `nofetch`=0, the channel reads four 4-byte words from the descriptor pointer with its low 4 bits forced to zero, at offsets 0, 4, 8 and 12. These load the next pointer, the source, the target and the command, in that order.
- R3: When pointer bit 1 and `cmp_flag` are both 1, the descriptor is read from 32 bytes above the aligned pointer.
- R4: Command bits 15:14 give the element width: 1→1 byte, 2→2 bytes, 3→4 bytes (0 is treated as 1 byte). Bit 31 steps the source and bit 30 steps the target by the width after each element; when the bit is clear that address stays fixed.
- R5: Each burst moves min(remaining length, 4<<cmd[17:16]) bytes. All of its reads complete before any of its writes. Narrow elements keep their little-endian byte order.
- R6: Command bits 12:0 hold the remaining byte length. They are reduced by each burst and are 0 after a full transfer.
- R7: Command bit 22 sets `st_start` when a descriptor is loaded. Command bit 21 sets `st_end` when the length reaches zero.
- R8: When the length reaches zero, `st_stop` is set. `run` is cleared if `nofetch` is 1, if next-pointer bit 0 is 1, or if `eor_stop_en` is 1; otherwise `run` stays 1.
- R9: Command bit 29 (source) or bit 28 (target) clears the low two bits of that address at load. With either bit set, no burst begins while `preq` is 0.
- R10: If `preq` is 0 after a flow-controlled burst, `st_eor` is set. With `eor_stop_en` the channel then stops with `run` still 1. Otherwise, with `eor_jump_en` and `nofetch`=0, it fetches the next descriptor.
- R11: On `go` with `nofetch`=1, no descriptor is read and the transfer uses the programmed source, target and command registers.
- R12: A zero length at start completes with no memory access and applies R7 and R8.
- R13: While `mem_valid` is 1 and `mem_ready` is 0, the request (`mem_addr`, `mem_write`, `mem_bytes`) is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe (accepted while stopped) |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 source, 2 target, 3 command |
| cfg_wdata | input | 32 | Register write data |
| go | input | 1 | Start pulse (accepted while stopped); clears all status |
| nofetch | input | 1 | Register-only mode, no descriptor fetch |
| eor_stop_en | input | 1 | Stop on end-of-receive |
| eor_jump_en | input | 1 | Fetch next descriptor on end-of-receive |
| cmp_flag | input | 1 | Compare status used for branch addressing |
| preq | input | 1 | Peripheral request |
| run | output | 1 | Run flag |
| st_start | output | 1 | Start status |
| st_end | output | 1 | End status |
| st_stop | output | 1 | Stopped status |
| st_eor | output | 1 | End-of-receive status |
| chan_desc | output | 32 | Next-descriptor pointer register |
| chan_src | output | 32 | Source address register |
| chan_dst | output | 32 | Target address register |
| chan_cmd | output | 32 | Command register with remaining length |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_bytes | output | 3 | Access size in bytes (1, 2 or 4) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, right-aligned, valid with ready |

## Verification
The hardest case to reach from the ports is an end-of-receive: the peripheral request has to fall exactly between the last write of one burst and the decision that follows it. The stimulus holds memory ready every cycle and watches the bench memory's write count. It drops the request on the clock edge after the first write is accepted, so the drop lands in the post-burst check. This is then combined with the stop option, and separately with the jump-to-next-descriptor option, where the fetched descriptor has zero length. Random transfers with random ready stalls cover widths, burst sizes, partial final bursts and the access order.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int LEN_W = 13;

  // command word bit positions
  localparam int C_INC_SRC  = 31;
  localparam int C_INC_DST  = 30;
  localparam int C_FLOW_SRC = 29;
  localparam int C_FLOW_DST = 28;
  localparam int C_START_IE = 22;
  localparam int C_END_IE   = 21;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_READ,
    S_WRITE,
    S_POST
  } dce_state_e;
endpackage

// File: rtl/dce_cmd_decode.sv
module dce_cmd_decode
  import dce_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  localparam int BURST_W  = $clog2(BUF_BYTES) + 1
) (
  input  logic [31:0]        cmd,
  output logic [LEN_W-1:0]   len,
  output logic [2:0]         elem_bytes,
  output logic [BURST_W-1:0] burst_bytes,
  output logic [2:0]         src_step,
  output logic [2:0]         dst_step,
  output logic               flow
);
  logic [LEN_W-1:0] cap;
  logic [LEN_W-1:0] burst_l;
  logic             unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd[27:18], cmd[13]};
  assign len = cmd[LEN_W-1:0];

  always_comb begin
    unique case (cmd[15:14])
      2'd2:    elem_bytes = 3'd2;
      2'd3:    elem_bytes = 3'd4;
      default: elem_bytes = 3'd1;
    endcase
  end

  assign cap         = LEN_W'(4) << cmd[17:16];
  assign burst_l     = (len < cap) ? len : cap;
  assign burst_bytes = burst_l[BURST_W-1:0];
  assign src_step    = cmd[C_INC_SRC] ? elem_bytes : 3'd0;
  assign dst_step    = cmd[C_INC_DST] ? elem_bytes : 3'd0;
  assign flow        = cmd[C_FLOW_SRC] | cmd[C_FLOW_DST];

  // R5: a burst never exceeds the local buffer
  always_comb begin
    a_r5_burst_fits: assert (burst_l <= LEN_W'(BUF_BYTES));
  end
endmodule

// File: rtl/dce_burst_buf.sv
module dce_burst_buf #(
  parameter int BYTES = 32,
  localparam int OFS_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [2:0]       wr_bytes,
  input  logic [31:0]      wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic [2:0]       rd_bytes,
  output logic [31:0]      rd_data
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (k < int'(wr_bytes)) mem[wr_ofs + OFS_W'(k)] <= wr_data[8*k +: 8];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(rd_bytes)) rd_data[8*k +: 8] = mem[rd_ofs + OFS_W'(k)];
    end
  end
endmodule

// File: rtl/dce_engine.sv
module dce_engine
  import dce_pkg::*;
#(
  parameter int BUF_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        go,
  input  logic        nofetch,
  input  logic        eor_stop_en,
  input  logic        eor_jump_en,
  input  logic        cmp_flag,
  input  logic        preq,
  output logic        run,
  output logic        st_start,
  output logic        st_end,
  output logic        st_stop,
  output logic        st_eor,
  output logic [31:0] chan_desc,
  output logic [31:0] chan_src,
  output logic [31:0] chan_dst,
  output logic [31:0] chan_cmd,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [2:0]  mem_bytes,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  localparam int OFS_W   = $clog2(BUF_BYTES);
  localparam int BURST_W = OFS_W + 1;

  dce_state_e         state_q;
  logic [31:0]        fetch_base_q;
  logic [1:0]         idx_q;
  logic [BURST_W-1:0] ofs_q;

  logic [LEN_W-1:0]   len;
  logic [2:0]         elem_bytes;
  logic [BURST_W-1:0] burst_bytes;
  logic [2:0]         src_step;
  logic [2:0]         dst_step;
  logic               flow;
  logic [BURST_W-1:0] ofs_nx;
  logic               last_elem;
  logic [31:0]        fetch_ptr;
  logic               xfer;

  dce_cmd_decode #(.BUF_BYTES(BUF_BYTES)) u_dec (
    .cmd(chan_cmd), .len(len), .elem_bytes(elem_bytes), .burst_bytes(burst_bytes),
    .src_step(src_step), .dst_step(dst_step), .flow(flow)
  );

  dce_burst_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk(clk),
    .wr_en(state_q == S_READ && xfer),
    .wr_ofs(ofs_q[OFS_W-1:0]), .wr_bytes(elem_bytes), .wr_data(mem_rdata),
    .rd_ofs(ofs_q[OFS_W-1:0]), .rd_bytes(elem_bytes), .rd_data(mem_wdata)
  );

  assign fetch_ptr = {chan_desc[31:4], 4'h0} + ((chan_desc[1] && cmp_flag) ? 32'd32 : 32'd0);
  assign ofs_nx    = ofs_q + BURST_W'(elem_bytes);
  assign last_elem = (ofs_nx >= burst_bytes);

  always_comb begin
    mem_valid = (state_q == S_FETCH) || (state_q == S_READ) || (state_q == S_WRITE);
    mem_write = (state_q == S_WRITE);
    mem_bytes = (state_q == S_FETCH) ? 3'd4 : elem_bytes;
    unique case (state_q)
      S_FETCH: mem_addr = fetch_base_q + {28'd0, idx_q, 2'b00};
      S_WRITE: mem_addr = chan_dst;
      default: mem_addr = chan_src;
    endcase
  end
  assign xfer = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      fetch_base_q <= '0;
      idx_q        <= '0;
      ofs_q        <= '0;
      chan_desc    <= '0;
      chan_src     <= '0;
      chan_dst     <= '0;
      chan_cmd     <= '0;
      run          <= 1'b0;
      st_start     <= 1'b0;
      st_end       <= 1'b0;
      st_stop      <= 1'b1;
      st_eor       <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cfg_we) begin
            unique case (cfg_sel)
              2'd0: chan_desc <= cfg_wdata;
              2'd1: chan_src  <= cfg_wdata;
              2'd2: chan_dst  <= cfg_wdata;
              default: chan_cmd <= cfg_wdata;
            endcase
          end
          if (go) begin
            run      <= 1'b1;
            st_stop  <= 1'b0;
            st_start <= 1'b0;
            st_end   <= 1'b0;
            st_eor   <= 1'b0;
            if (nofetch) begin
              state_q <= S_CHECK;
            end else begin
              fetch_base_q <= fetch_ptr;
              idx_q        <= '0;
              state_q      <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (xfer) begin
            idx_q <= idx_q + 2'd1;
            unique case (idx_q)
              2'd0: chan_desc <= mem_rdata;
              2'd1: chan_src  <= mem_rdata;
              2'd2: chan_dst  <= mem_rdata;
              default: begin
                chan_cmd <= mem_rdata;
                if (mem_rdata[C_FLOW_SRC]) chan_src <= chan_src & ~32'h3;
                if (mem_rdata[C_FLOW_DST]) chan_dst <= chan_dst & ~32'h3;
                if (mem_rdata[C_START_IE]) st_start <= 1'b1;
                state_q <= S_CHECK;
              end
            endcase
          end
        end
        S_CHECK: begin
          if (len == '0) begin
            if (chan_cmd[C_END_IE]) st_end <= 1'b1;
            st_stop <= 1'b1;
            if (nofetch || chan_desc[0] || eor_stop_en) run <= 1'b0;
            state_q <= S_IDLE;
          end else if (!flow || preq) begin
            ofs_q   <= '0;
            state_q <= S_READ;
          end
        end
        S_READ: begin
          if (xfer) begin
            chan_src <= chan_src + {29'd0, src_step};
            if (last_elem) begin
              ofs_q   <= '0;
              state_q <= S_WRITE;
            end else begin
              ofs_q <= ofs_nx;
            end
          end
        end
        S_WRITE: begin
          if (xfer) begin
            chan_dst <= chan_dst + {29'd0, dst_step};
            if (last_elem) begin
              chan_cmd[LEN_W-1:0] <= len - LEN_W'(burst_bytes);
              state_q <= S_POST;
            end else begin
              ofs_q <= ofs_nx;
            end
          end
        end
        default: begin
          if (flow && !preq) begin
            st_eor <= 1'b1;
            if (eor_stop_en) begin
              st_stop <= 1'b1;
              state_q <= S_IDLE;
            end else if (eor_jump_en && !nofetch) begin
              fetch_base_q <= fetch_ptr;
              idx_q        <= '0;
              state_q      <= S_FETCH;
            end else begin
              state_q <= S_CHECK;
            end
          end else begin
            state_q <= S_CHECK;
          end
        end
      endcase
    end
  end

  // R13: a stalled request keeps its address, direction and size
  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_bytes));

  // R6: outside a fetch and a register write, the remaining length never grows
  a_r6_len_no_rise: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_FETCH && !cfg_we) |=> chan_cmd[LEN_W-1:0] <= $past(chan_cmd[LEN_W-1:0]));

  // R8: a stopped channel makes no memory request
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    st_stop |-> !mem_valid);

  // R9: with flow control and no request, no burst begins
  a_r9_flow_gate: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CHECK && flow && !preq) |=> !mem_valid);

  // R12: zero length completes without touching memory
  a_r12_zero_len: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CHECK && len == '0) |=> !mem_valid && st_stop);
endmodule

// File: tb/dce_engine_test.sv
module dce_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        go = 1'b0, nofetch = 1'b0, eor_stop_en = 1'b0, eor_jump_en = 1'b0;
  logic        cmp_flag = 1'b0, preq = 1'b0;
  logic        run, st_start, st_end, st_stop, st_eor;
  logic [31:0] chan_desc, chan_src, chan_dst, chan_cmd;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [2:0]  mem_bytes;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [7:0]  mem [MEM_BYTES];
  logic        tr_w [512];
  logic [31:0] tr_a [512];
  int          n_acc, n_wr;
  logic        rand_ready = 1'b0;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  dce_engine uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .go(go), .nofetch(nofetch), .eor_stop_en(eor_stop_en), .eor_jump_en(eor_jump_en),
    .cmp_flag(cmp_flag), .preq(preq), .run(run), .st_start(st_start), .st_end(st_end),
    .st_stop(st_stop), .st_eor(st_eor), .chan_desc(chan_desc), .chan_src(chan_src),
    .chan_dst(chan_dst), .chan_cmd(chan_cmd), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: decides ready and completes the access seen between edges
  always @(negedge clk) begin
    logic        rdy;
    logic [31:0] rd;
    rdy = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
    rd  = '0;
    if (mem_valid && rdy) begin
      if (n_acc < 512) begin
        tr_w[n_acc] = mem_write;
        tr_a[n_acc] = mem_addr;
      end
      n_acc = n_acc + 1;
      for (int k = 0; k < 4; k++) begin
        if (k < int'(mem_bytes)) begin
          if (mem_write) mem[(mem_addr + k) % MEM_BYTES] = mem_wdata[8*k +: 8];
          else rd[8*k +: 8] = mem[(mem_addr + k) % MEM_BYTES];
        end
      end
      if (mem_write) n_wr = n_wr + 1;
    end
    mem_ready = rdy;
    mem_rdata = rd;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[(a + k) % MEM_BYTES] = v[8*k +: 8];
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic clear_trace();
    @(posedge clk); n_acc = 0; n_wr = 0;
  endtask

  task automatic start_and_wait(input logic nf);
    @(negedge clk); nofetch = nf; go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int i = 0; i < 20000 && !st_stop; i++) @(negedge clk);
  endtask

  function automatic int wbytes(input int code);
    return (code == 2) ? 2 : (code == 3) ? 4 : 1;
  endfunction

  // random descriptor transfer, incrementing addresses
  task automatic rand_xfer(input int t);
    int wc, bc, w, elems, len, src, dst, bsz, rem, b, i, mis;
    logic sie, nb0;
    logic [31:0] cmd;
    bit ord_ok;
    wc = $urandom_range(1, 3); bc = $urandom_range(0, 3); w = wbytes(wc);
    elems = $urandom_range(1, 30); len = elems * w;
    src = 32'h400 + $urandom_range(0, 63) * 4;
    dst = 32'h1000 + $urandom_range(0, 63) * 4;
    sie = 1'($urandom_range(0, 1)); nb0 = 1'($urandom_range(0, 1));
    for (int k = 0; k < len; k++) begin
      mem[src + k] = 8'($urandom);
      mem[dst + k] = 8'h00;
    end
    cmd = (32'h1 << 31) | (32'h1 << 30) | (32'(bc) << 16) | (32'(wc) << 14) | (32'h1 << 21)
        | (32'(sie) << 22) | 32'(len);
    put32(32'h100, 32'h300 | 32'(nb0));
    put32(32'h104, src); put32(32'h108, dst); put32(32'h10C, cmd);
    cfg(2'd0, 32'h100);
    clear_trace();
    start_and_wait(1'b0);
    mis = 0;
    for (int k = 0; k < len; k++) if (mem[dst + k] !== mem[src + k]) mis++;
    chk("R5", $sformatf("t%0d data mismatches", t), mis, 0);
    chk("R6", "remaining length", {19'd0, chan_cmd[12:0]}, 0);
    chk("R4", "source end", chan_src, src + len);
    chk("R4", "target end", chan_dst, dst + len);
    chk("R2", "next pointer", chan_desc, 32'h300 | 32'(nb0));
    chk("R7", "end status", st_end, 1);
    chk("R7", "start status", st_start, sie);
    chk("R8", "stop status", st_stop, 1);
    chk("R8", "run after end", run, !nb0);
    // expected access order: 4 fetch reads, then per burst k reads then k writes
    bsz = 4 << bc; rem = len; i = 4; ord_ok = (n_acc == 4 + 2 * elems);
    for (int f = 0; f < 4; f++) if (tr_w[f] !== 1'b0 || tr_a[f] !== 32'h100 + f * 4) ord_ok = 0;
    while (rem > 0 && i < 512) begin
      b = (rem < bsz) ? rem : bsz;
      for (int e = 0; e < b / w; e++) begin if (tr_w[i] !== 1'b0) ord_ok = 0; i++; end
      for (int e = 0; e < b / w; e++) begin if (tr_w[i] !== 1'b1) ord_ok = 0; i++; end
      rem -= b;
    end
    chk("R5", "read-all-then-write order", ord_ok, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < MEM_BYTES; k++) mem[k] = 8'h00;
    n_acc = 0; n_wr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "stop", st_stop, 1);
    chk("R1", "run", run, 0);
    chk("R1", "other status", {st_start, st_end, st_eor}, 0);
    chk("R1", "command", chan_cmd, 0);
    chk("R1", "mem_valid", mem_valid, 0);

    // R2 R4 R5 R6 R7 R8 R13: random transfers with stalls
    rand_ready = 1'b1;
    for (int t = 0; t < 14; t++) rand_xfer(t);
    rand_ready = 1'b0;

    // R4 fixed addresses, 2-byte elements, 2 elements per burst
    mem[32'h600] = 8'hEF; mem[32'h601] = 8'hBE; mem[32'h602] = 8'h11; mem[32'h603] = 8'h22;
    for (int k = 0; k < 4; k++) mem[32'h1A00 + k] = 8'h00;
    cfg(2'd1, 32'h600); cfg(2'd2, 32'h1A00); cfg(2'd3, (32'd2 << 14) | 32'd8);
    clear_trace();
    start_and_wait(1'b1);
    chk("R4", "fixed target value", {mem[32'h1A03], mem[32'h1A02], mem[32'h1A01], mem[32'h1A00]}, 32'h0000BEEF);
    chk("R4", "fixed source held", chan_src, 32'h600);
    chk("R4", "fixed target held", chan_dst, 32'h1A00);
    chk("R11", "no fetch access count", n_acc, 8);
    chk("R8", "run cleared in register mode", run, 0);

    // R11 register-only transfer, 4-byte elements
    put32(32'h700, 32'hA1B2C3D4); put32(32'h704, 32'h01020304);
    cfg(2'd1, 32'h700); cfg(2'd2, 32'h1B00);
    cfg(2'd3, (32'h1 << 31) | (32'h1 << 30) | (32'd1 << 16) | (32'd3 << 14) | 32'd8);
    clear_trace();
    start_and_wait(1'b1);
    chk("R11", "access count", n_acc, 4);
    chk("R11", "first access is source", tr_a[0], 32'h700);
    chk("R11", "copied word", {mem[32'h1B07], mem[32'h1B06], mem[32'h1B05], mem[32'h1B04]}, 32'h01020304);

    // R12 zero length in register mode
    cfg(2'd3, 32'h1 << 21);
    clear_trace();
    start_and_wait(1'b1);
    chk("R12", "no memory access", n_acc, 0);
    chk("R12", "end status", st_end, 1);
    chk("R12", "stop status", st_stop, 1);
    chk("R12", "run cleared", run, 0);

    // R3 compare-branch descriptor addressing
    put32(32'h200, 32'hA01); put32(32'h20C, 32'h0);
    put32(32'h220, 32'hB01); put32(32'h22C, 32'h0);
    cmp_flag = 1'b1; cfg(2'd0, 32'h202);
    clear_trace(); start_and_wait(1'b0);
    chk("R3", "branch taken pointer", chan_desc, 32'hB01);
    chk("R3", "branch fetch address", tr_a[0], 32'h220);
    cmp_flag = 1'b0; cfg(2'd0, 32'h202);
    clear_trace(); start_and_wait(1'b0);
    chk("R3", "no compare, no branch", chan_desc, 32'hA01);
    cmp_flag = 1'b1; cfg(2'd0, 32'h205);
    clear_trace(); start_and_wait(1'b0);
    chk("R2", "low bits forced to zero", tr_a[0], 32'h200);
    cmp_flag = 1'b0;

    // R9 R10 flow control with end-of-receive stop
    put32(32'h500, 32'hCAFEF00D);
    put32(32'h280, 32'h2C0); put32(32'h284, 32'h503); put32(32'h288, 32'h1800);
    put32(32'h28C, (32'h1 << 29) | (32'h1 << 30) | (32'd3 << 14) | 32'd12);
    put32(32'h1800, 32'h0);
    eor_stop_en = 1'b1; eor_jump_en = 1'b0; preq = 1'b0;
    cfg(2'd0, 32'h280);
    clear_trace();
    @(negedge clk); nofetch = 1'b0; go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9", "no burst without request", n_acc, 4);
    chk("R9", "source low bits cleared", chan_src, 32'h500);
    preq = 1'b1;
    for (int i = 0; i < 200 && n_wr < 1; i++) @(posedge clk);
    @(negedge clk); preq = 1'b0;
    for (int i = 0; i < 200 && !st_stop; i++) @(negedge clk);
    chk("R10", "eor status", st_eor, 1);
    chk("R10", "stopped", st_stop, 1);
    chk("R10", "run kept", run, 1);
    chk("R6", "length after one burst", {19'd0, chan_cmd[12:0]}, 8);
    chk("R9", "fixed flow source", chan_src, 32'h500);
    chk("R10", "target after one burst", chan_dst, 32'h1804);
    chk("R5", "burst data", {mem[32'h1803], mem[32'h1802], mem[32'h1801], mem[32'h1800]}, 32'hCAFEF00D);

    // R10 end-of-receive jump to the next descriptor
    put32(32'h2C0, 32'h1); put32(32'h2C4, 32'h0); put32(32'h2C8, 32'h0);
    put32(32'h2CC, (32'h1 << 22) | (32'h1 << 21));
    eor_stop_en = 1'b0; eor_jump_en = 1'b1;
    cfg(2'd0, 32'h280);
    clear_trace();
    @(negedge clk); go = 1'b1; preq = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int i = 0; i < 200 && n_wr < 1; i++) @(posedge clk);
    @(negedge clk); preq = 1'b0;
    for (int i = 0; i < 200 && !st_stop; i++) @(negedge clk);
    chk("R10", "jump eor status", st_eor, 1);
    chk("R10", "jump fetched next", chan_desc, 32'h1);
    chk("R7", "start on jumped descriptor", st_start, 1);
    chk("R7", "end on jumped descriptor", st_end, 1);
    chk("R8", "run cleared by pointer bit 0", run, 0);
    chk("R10", "jump access count", n_acc, 10);
    chk("R10", "jump fetch address", tr_a[6], 32'h2C0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule